// File: doc/BRIEF.md
# Four-Stage Conversion Result FIFO

This block queues analog-to-digital conversion results for software. Each entry holds a 12-bit sample, a 3-bit code that records what started the conversion, and the 5-bit number of the input channel. Software reads the entries through a single 32-bit data port. That port accepts byte, half-word and word reads, selected by byte enables. Only a read that covers the most significant byte removes the head entry. Software can therefore look at the low bytes of the head entry without consuming it.

A 2-bit threshold selects which FIFO stage raises a sticky interrupt flag when a result is written into it. A second sticky flag records a result that was lost because the queue was full. Software clears each flag with a strobe.

Top module: `conv_fifo`

## Requirements
- R1: The queue holds at most four results and returns them in the order they were written.
- R2: The read word places the result in bits 31:20, the invalid flag in bit 12, the start code in bits 10:8 and the channel in bits 4:0. Every other bit reads 0.
- R3: When the queue is empty, the read word is 0x00001000, with only the invalid flag set. A popping read of an empty queue changes nothing.
- R4: Byte enable bit k selects data bits 8k+7:8k. A read pops the head entry when rdStrobe is high and rdByteEn[3] is set. This covers a top-byte read (1000), a top-half read (1100) and a word read (1111).
- R5: A read with rdByteEn[3] clear leaves the queue unchanged. Examples are 0001, 0010, 0100 and 0011. The next read returns the same head entry.
- R6: The threshold register resets to 0. It loads thrIn in the cycle thrWe is high and is visible on thrOut.
- R7: When a write is accepted and the queue level after it equals threshold + 1, irqFlag is 1 from the next cycle on. A pop in the same cycle counts before the write.
- R8: irqFlag stays 1 until irqClr is pulsed. If a new threshold crossing happens in the same cycle as irqClr, the flag stays 1.
- R9: A write to a full queue with no pop in the same cycle is dropped, and ovrFlag becomes 1. A write and a pop in the same cycle on a full queue are both performed.
- R10: ovrClr clears ovrFlag. A dropped write in the same cycle as ovrClr leaves ovrFlag at 1.
- R11: After reset the queue is empty and both flags are 0.
- R12: Byte lanes whose enable bit is 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write one result this cycle |
| wrResult | input | 12 | Conversion sample |
| wrFactor | input | 3 | Start-cause code |
| wrChan | input | 5 | Input channel number |
| rdStrobe | input | 1 | Read access this cycle |
| rdByteEn | input | 4 | Byte lanes of the read |
| rdData | output | 32 | Head entry word, masked by lanes |
| thrWe | input | 1 | Load the threshold |
| thrIn | input | 2 | New threshold stage code |
| thrOut | output | 2 | Current threshold |
| irqClr | input | 1 | Clear the fill interrupt flag |
| irqFlag | output | 1 | Fill interrupt flag |
| ovrClr | input | 1 | Clear the overrun flag |
| ovrFlag | output | 1 | Overrun flag |

## Verification
The assertions assume that every input is a clean synchronous level, that rdByteEn matters only while rdStrobe is high, and that a write carries no X on its data fields. The stimulus changes inputs only on the falling clock edge and holds them for one full cycle. It drives the byte enables only in the patterns that a byte, half-word or word access produces. It writes the threshold only while no result is being written, so every crossing is measured against a settled threshold.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;
  // field positions inside the 32-bit read word
  localparam int RES_LSB = 20;
  localparam int INV_BIT = 12;
  localparam int FAC_LSB = 8;
  localparam int CH_LSB  = 0;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;

  typedef struct packed {
    logic push;   // store the write-side entry
    logic pop;    // retire the head entry
    logic empty;  // no valid head entry
  } fifoStrobe_t;
endpackage

// File: rtl/conv_fifo_ctrl.sv
module conv_fifo_ctrl
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int THR_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             rdTopLane,
  input  logic             thrWe,
  input  logic [THR_W-1:0] thrIn,
  input  logic             irqClr,
  input  logic             ovrClr,
  output fifoStrobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] level,
  output logic [THR_W-1:0] thrOut,
  output logic             irqFlag,
  output logic             ovrFlag
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic             isEmpty;
  logic             isFull;
  logic             popOk;
  logic             pushOk;
  logic [CNT_W-1:0] levelAfterPop;
  logic             stageHit;
  logic             overrunHit;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    isEmpty       = (level == '0);
    isFull        = (level == FULL_LVL);
    popOk         = rdTopLane && !isEmpty;
    pushOk        = wrValid && (!isFull || popOk);
    levelAfterPop = level - CNT_W'(popOk);
    stageHit      = pushOk && (levelAfterPop == CNT_W'(thrOut));
    overrunHit    = wrValid && isFull && !popOk;
    strobe.push   = pushOk;
    strobe.pop    = popOk;
    strobe.empty  = isEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= advance(wrPtr);
      if (popOk)  rdPtr <= advance(rdPtr);
      level <= levelAfterPop + CNT_W'(pushOk);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrOut  <= '0;
      irqFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      if (thrWe) thrOut <= thrIn;
      irqFlag <= stageHit || (irqFlag && !irqClr);
      ovrFlag <= overrunHit || (ovrFlag && !ovrClr);
    end
  end
endmodule

// File: rtl/conv_fifo_dp.sv
module conv_fifo_dp
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RES_W = 12,
  parameter int FAC_W = 3,
  parameter int CH_W  = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  fifoStrobe_t      strobe,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [RES_W-1:0] wrResult,
  input  logic [FAC_W-1:0] wrFactor,
  input  logic [CH_W-1:0]  wrChan,
  input  logic [LANES-1:0] laneEn,
  output logic [BUS_W-1:0] rdData
);
  localparam int ENT_W = RES_W + FAC_W + CH_W;

  logic [ENT_W-1:0] store [DEPTH];
  logic [ENT_W-1:0] head;
  logic [BUS_W-1:0] packed_word;

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= {wrResult, wrFactor, wrChan};
  end

  assign head = store[rdPtr];

  always_comb begin
    packed_word = '0;
    if (strobe.empty) begin
      packed_word[INV_BIT] = 1'b1;
    end else begin
      packed_word[RES_LSB +: RES_W] = head[ENT_W-1 -: RES_W];
      packed_word[FAC_LSB +: FAC_W] = head[CH_W +: FAC_W];
      packed_word[CH_LSB  +: CH_W]  = head[CH_W-1:0];
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    assign rdData[lane*8 +: 8] = laneEn[lane] ? packed_word[lane*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/conv_fifo.sv
module conv_fifo
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RES_W = 12,
  parameter int FAC_W = 3,
  parameter int CH_W  = 5,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [RES_W-1:0] wrResult,
  input  logic [FAC_W-1:0] wrFactor,
  input  logic [CH_W-1:0]  wrChan,
  input  logic             rdStrobe,
  input  logic [LANES-1:0] rdByteEn,
  output logic [BUS_W-1:0] rdData,
  input  logic             thrWe,
  input  logic [THR_W-1:0] thrIn,
  output logic [THR_W-1:0] thrOut,
  input  logic             irqClr,
  output logic             irqFlag,
  input  logic             ovrClr,
  output logic             ovrFlag
);
  fifoStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fillLevel;
  logic             rdTopLane;

  // a read pops only when it covers the most significant byte lane
  assign rdTopLane = rdStrobe && rdByteEn[LANES-1];

  conv_fifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdTopLane(rdTopLane),
    .thrWe(thrWe), .thrIn(thrIn), .irqClr(irqClr), .ovrClr(ovrClr),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .level(fillLevel),
    .thrOut(thrOut), .irqFlag(irqFlag), .ovrFlag(ovrFlag)
  );

  conv_fifo_dp #(.DEPTH(DEPTH), .RES_W(RES_W), .FAC_W(FAC_W), .CH_W(CH_W)) uDp (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrResult(wrResult), .wrFactor(wrFactor), .wrChan(wrChan),
    .laneEn(rdByteEn), .rdData(rdData)
  );
endmodule

// File: rtl/conv_fifo_chk.sv
module conv_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int THR_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             rdStrobe,
  input logic [3:0]       rdByteEn,
  input logic [31:0]      rdData,
  input logic             thrWe,
  input logic [THR_W-1:0] thrOut,
  input logic             irqClr,
  input logic             irqFlag,
  input logic             ovrFlag,
  input logic [CNT_W-1:0] fillLevel
);
  a_r1_level_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH));

  a_r3_empty_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0) && rdByteEn[1] |-> rdData[12]);

  a_r5_low_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !rdByteEn[3] && !wrValid |=> $stable(fillLevel));

  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && (fillLevel == CNT_W'(DEPTH)) && !(rdStrobe && rdByteEn[3]) |=> ovrFlag);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !irqClr |=> irqFlag);

  a_r6_thr_holds: assert property (@(posedge clk) disable iff (!rstN)
    !thrWe |=> $stable(thrOut));
endmodule

bind conv_fifo conv_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
  .rdByteEn(rdByteEn), .rdData(rdData), .thrWe(thrWe), .thrOut(thrOut),
  .irqClr(irqClr), .irqFlag(irqFlag), .ovrFlag(ovrFlag), .fillLevel(fillLevel)
);

// File: tb/sim_conv_fifo.sv
module sim_conv_fifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [11:0] wrResult = '0;
  logic [2:0]  wrFactor = '0;
  logic [4:0]  wrChan = '0;
  logic        rdStrobe = 1'b0;
  logic [3:0]  rdByteEn = '0;
  logic [31:0] rdData;
  logic        thrWe = 1'b0;
  logic [1:0]  thrIn = '0;
  logic [1:0]  thrOut;
  logic        irqClr = 1'b0;
  logic        irqFlag;
  logic        ovrClr = 1'b0;
  logic        ovrFlag;

  int checks = 0;
  int fails = 0;
  logic [19:0] sb [$];   // scoreboard of expected entries
  int  thrModel = 0;
  bit  irqModel = 0;
  bit  ovrModel = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  conv_fifo u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrResult(wrResult),
    .wrFactor(wrFactor), .wrChan(wrChan), .rdStrobe(rdStrobe),
    .rdByteEn(rdByteEn), .rdData(rdData), .thrWe(thrWe), .thrIn(thrIn),
    .thrOut(thrOut), .irqClr(irqClr), .irqFlag(irqFlag),
    .ovrClr(ovrClr), .ovrFlag(ovrFlag)
  );

  function automatic logic [31:0] expWord(input logic [3:0] be);
    logic [31:0] w;
    if (sb.size() == 0) w = 32'h0000_1000;
    else w = {sb[0][19:8], 7'b0, 1'b0, 1'b0, sb[0][7:5], 3'b0, sb[0][4:0]};
    for (int k = 0; k < 4; k++) if (!be[k]) w[k*8 +: 8] = 8'h00;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, updates the scoreboard, compares outputs
  task automatic step(input bit w, input logic [11:0] r, input logic [2:0] f,
                      input logic [4:0] c, input bit rd, input logic [3:0] be,
                      input bit iclr, input bit oclr, input string tag);
    bit popE, pushE, irqSet, ovrSet;
    int lvlAfterPop;
    wrValid = w; wrResult = r; wrFactor = f; wrChan = c;
    rdStrobe = rd; rdByteEn = be; irqClr = iclr; ovrClr = oclr;
    #1;
    if (rd) check({tag, " data"}, rdData, expWord(be));
    popE = rd && be[3] && (sb.size() > 0);
    pushE = w && ((sb.size() < 4) || popE);
    lvlAfterPop = sb.size() - (popE ? 1 : 0);
    irqSet = pushE && (lvlAfterPop == thrModel);
    ovrSet = w && (sb.size() == 4) && !popE;
    @(posedge clk);
    if (popE) void'(sb.pop_front());
    if (pushE) sb.push_back({r, f, c});
    irqModel = irqSet || (irqModel && !iclr);
    ovrModel = ovrSet || (ovrModel && !oclr);
    @(negedge clk);
    wrValid = 0; rdStrobe = 0; rdByteEn = '0; irqClr = 0; ovrClr = 0;
    check({tag, " irq"}, {31'b0, irqFlag}, {31'b0, irqModel});
    check({tag, " ovr"}, {31'b0, ovrFlag}, {31'b0, ovrModel});
  endtask

  task automatic setThr(input logic [1:0] v);
    thrWe = 1; thrIn = v;
    @(negedge clk);
    thrWe = 0;
    thrModel = v;
    check("R6 thr", {30'b0, thrOut}, {30'b0, v});
  endtask

  task automatic wr(input logic [11:0] r, input logic [2:0] f, input logic [4:0] c, input string tag);
    step(1, r, f, c, 0, 4'b0000, 0, 0, tag);
  endtask

  task automatic rdx(input logic [3:0] be, input string tag);
    step(0, '0, '0, '0, 1, be, 0, 0, tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 / R6: reset state
    check("R11 irq", {31'b0, irqFlag}, 32'h0);
    check("R11 ovr", {31'b0, ovrFlag}, 32'h0);
    check("R6 reset thr", {30'b0, thrOut}, 32'h0);
    rdx(4'b1111, "R3 R11 empty");
    rdx(4'b1111, "R3 empty again");

    setThr(2'd0);
    wr(12'hABC, 3'b001, 5'd3, "R7 stage1");
    step(0, '0, '0, '0, 0, 4'b0, 1, 0, "R8 clear");
    rdx(4'b0001, "R5 R12 byte0");
    rdx(4'b0010, "R5 R2 byte1");
    rdx(4'b0100, "R5 byte2");
    rdx(4'b0011, "R5 low half");
    rdx(4'b1000, "R4 top byte");
    rdx(4'b1111, "R3 empty after pop");

    setThr(2'd2);
    wr(12'h123, 3'b010, 5'd17, "R7 below");
    wr(12'hFFF, 3'b100, 5'd7,  "R7 below2");
    wr(12'h5A5, 3'b001, 5'd31, "R7 stage3");
    wr(12'h001, 3'b010, 5'd0,  "R8 sticky");
    wr(12'h777, 3'b100, 5'd9,  "R9 drop");
    rdx(4'b1100, "R4 R1 top half");
    rdx(4'b1111, "R1 R2 word");
    rdx(4'b1000, "R1 top byte");
    rdx(4'b0011, "R5 R12 low half");
    rdx(4'b1111, "R1 last");
    rdx(4'b1111, "R3 drained");
    step(0, '0, '0, '0, 0, 4'b0, 0, 1, "R10 clear");
    step(0, '0, '0, '0, 0, 4'b0, 1, 0, "R8 clear2");

    setThr(2'd3);
    wr(12'h100, 3'b001, 5'd1, "R7 s1");
    wr(12'h200, 3'b010, 5'd2, "R7 s2");
    wr(12'h300, 3'b100, 5'd4, "R7 s3");
    wr(12'h400, 3'b001, 5'd8, "R7 stage4");
    step(1, 12'h500, 3'b010, 5'd16, 0, 4'b0, 0, 1, "R10 set wins");
    step(1, 12'h600, 3'b100, 5'd30, 1, 4'b1111, 0, 0, "R9 push pop full");
    step(0, '0, '0, '0, 0, 4'b0, 1, 1, "R10 clear3");
    for (int i = 0; i < 5; i++) rdx(4'b1111, "R1 drain");

    setThr(2'd0);
    step(1, 12'hC3C, 3'b001, 5'd12, 0, 4'b0, 1, 0, "R8 set beats clear");
    rdx(4'b1111, "R2 final");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule